// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 16-bit core that switches control to an interrupt handler. At each instruction boundary the core pulses `instr_done`. The block then looks at the pending sources in a fixed priority order and picks one. It stacks the flags word, the code segment and a return offset in three downward word pushes. It clears the interrupt-enable and trap flags, reads a two-word vector from a table of 4-byte entries at the bottom of memory, and loads the new code segment and instruction pointer. A separate `iret_req` pulse reverses the frame: it pops the instruction pointer, the code segment and the flags, and moves the stack pointer back up.

The architectural FLAGS, CS, IP and SP registers are held inside the block. The core sees them on output ports and writes them through a simple load port. Stack and table traffic goes over one synchronous word port: a write takes effect at the clock edge of the request, and read data arrives on `mem_rdata` in the cycle after the request. An external request is acknowledged with a one-cycle `inta` pulse, and the vector byte is taken in that same cycle. While a sequence runs, `busy` is high and every boundary, return and load request is ignored.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, FLAGS reads 0x0002, CS, IP and SP read 0, and `busy`, `inta` and `mem_req` are low.
- R2: An `instr_done` pulse with nothing pending copies `next_ip` into IP, makes no memory access and leaves `busy` low.
- R3: Sources are taken one at a time in this order, highest first: exception (vector `exc_vec`), single step (vector 1, only while TF = FLAGS bit 8 is set), NMI (vector 2), coprocessor overrun (vector 9), external request (only while IF = FLAGS bit 9 is set), software interrupt (vector `swi_vec`).
- R4: Entry writes three words: the old FLAGS at SS*16+SP-2, CS at SS*16+SP-4 and the return offset at SS*16+SP-6. SP drops by 2 with each push and ends 6 lower.
- R5: IF (bit 9) and TF (bit 8) of FLAGS are cleared right after FLAGS has been pushed, before the vector is read. The stacked copy keeps their old values.
- R6: For vector n, the word at byte address 4n becomes the new IP and the word at 4n+2 becomes the new CS.
- R7: An exception whose vector is 0, 5, 6, 7, 8, 10, 11, 12 or 13 stacks the current IP. Every other accepted source stacks `next_ip`.
- R8: An external request is ignored while IF is 0. When it is accepted, `inta` is high for exactly one cycle and the vector is taken from `intr_vec` in that cycle.
- R9: `busy` is high from acceptance until the new CS:IP is loaded: 6 cycles, or 7 for an external request. Any `instr_done`, `iret_req` or `wr_en` seen during that time has no effect.
- R10: `iret_req` while idle reads IP from SS*16+SP, CS from +2 and FLAGS from +4, raises SP by 6 and holds `busy` for 4 cycles.
- R11: `wr_en` while idle loads FLAGS, CS, IP and SP from the write port. It is ignored in a cycle where `instr_done` or `iret_req` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction boundary pulse |
| next_ip | input | 16 | Offset of the following instruction |
| iret_req | input | 1 | Start a return-from-interrupt |
| wr_en | input | 1 | Load architectural registers |
| wr_flags | input | 16 | FLAGS load value |
| wr_cs | input | 16 | CS load value |
| wr_ip | input | 16 | IP load value |
| wr_sp | input | 16 | SP load value |
| ss_i | input | 16 | Stack segment |
| exc_req | input | 1 | Internal exception pending |
| exc_vec | input | 8 | Exception vector |
| nmi_req | input | 1 | Non-maskable request pending |
| ovr_req | input | 1 | Coprocessor overrun pending |
| intr_req | input | 1 | Maskable external request |
| intr_vec | input | 8 | External vector byte, read during acknowledge |
| swi_req | input | 1 | Software interrupt pending |
| swi_vec | input | 8 | Software interrupt vector |
| inta | output | 1 | Acknowledge pulse for the external request |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| flags_o | output | 16 | FLAGS register |
| cs_o | output | 16 | CS register |
| ip_o | output | 16 | IP register |
| sp_o | output | 16 | SP register |

## Verification
A table holding a distinct offset and segment for each vector lets the final CS:IP show which source won. Each priority test stacks several sources at once and then removes the winner, so every adjacent pair in the order is separated. An exception is raised once with a retry-class vector and once with a plain vector to tell the current-IP frame from the next-IP frame. An external request is raised with IF cleared and then with IF set, which tells gating from acknowledge. A boundary pulse injected in the middle of a sequence, and a load request raised together with a boundary pulse, show that the ignored inputs leave the frame, SP and CS untouched.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK, ST_PSH_F, ST_PSH_CS, ST_PSH_IP,
    ST_RD_OFF, ST_RD_SEG, ST_LOAD,
    ST_POP_IP, ST_POP_CS, ST_POP_F, ST_POP_END
  } seq_st_e;

  // order of the values 1..6 is the acceptance priority, highest first
  typedef enum logic [2:0] {
    SRC_NONE, SRC_EXC, SRC_STEP, SRC_NMI, SRC_OVR, SRC_EXT, SRC_SWI
  } src_e;

  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;

endpackage

// File: rtl/irq_pri_sel.sv
module irq_pri_sel
  import irq_seq_pkg::*;
#(
  parameter int VW = 8,
  parameter logic [(1<<VW)-1:0] RETRY_MASK = 'h3DE1,
  parameter logic [VW-1:0] STEP_VEC = 1,
  parameter logic [VW-1:0] NMI_VEC  = 2,
  parameter logic [VW-1:0] OVR_VEC  = 9
) (
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          trap_en,
  input  logic          nmi_req,
  input  logic          ovr_req,
  input  logic          ext_req,
  input  logic          ext_en,
  input  logic          swi_req,
  input  logic [VW-1:0] swi_vec,
  output src_e          src,
  output logic [VW-1:0] vec,
  output logic          use_cur
);

  localparam int NSRC = 6;

  logic [NSRC-1:0] req;
  logic [VW-1:0]   vtab [NSRC];

  // index 0 is the highest priority
  assign req = {swi_req, ext_req & ext_en, ovr_req, nmi_req, trap_en, exc_req};

  always_comb begin
    vtab[0] = exc_vec;
    vtab[1] = STEP_VEC;
    vtab[2] = NMI_VEC;
    vtab[3] = OVR_VEC;
    vtab[4] = '0;       // supplied during acknowledge
    vtab[5] = swi_vec;
  end

  always_comb begin
    src = SRC_NONE;
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        src = src_e'(3'(i + 1));
        vec = vtab[i];
      end
    end
  end

  assign use_cur = (src == SRC_EXC) && RETRY_MASK[exc_vec];

endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen
  import irq_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int VW = 8
) (
  input  seq_st_e       state,
  input  logic [DW-1:0] ss,
  input  logic [DW-1:0] sp,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] base;
  logic [DW-1:0] sp_ofs;
  logic [AW-1:0] tbl;

  assign base = AW'({ss, 4'h0});
  assign tbl  = AW'({vec, 2'b00});

  always_comb begin
    unique case (state)
      ST_PSH_F, ST_PSH_CS, ST_PSH_IP: sp_ofs = sp - DW'(2);
      ST_POP_CS:                      sp_ofs = sp + DW'(2);
      ST_POP_F:                       sp_ofs = sp + DW'(4);
      default:                        sp_ofs = sp;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_RD_OFF: addr = tbl;
      ST_RD_SEG: addr = tbl + AW'(2);
      default:   addr = base + AW'(sp_ofs);
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int VW = 8,
  parameter logic [DW-1:0] FLAGS_RST = 16'h0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic [DW-1:0] next_ip,
  input  logic          iret_req,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_flags,
  input  logic [DW-1:0] wr_cs,
  input  logic [DW-1:0] wr_ip,
  input  logic [DW-1:0] wr_sp,
  input  logic [DW-1:0] ss_i,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          nmi_req,
  input  logic          ovr_req,
  input  logic          intr_req,
  input  logic [VW-1:0] intr_vec,
  input  logic          swi_req,
  input  logic [VW-1:0] swi_vec,
  output logic          inta,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o
);

  seq_st_e       state, state_n;
  logic [DW-1:0] flags, flags_n;
  logic [DW-1:0] cs, cs_n;
  logic [DW-1:0] ip, ip_n;
  logic [DW-1:0] sp, sp_n;
  logic [DW-1:0] ret_q, ret_n;
  logic [DW-1:0] off_q, off_n;
  logic [VW-1:0] vec_q, vec_n;

  src_e          sel_src;
  logic [VW-1:0] sel_vec;
  logic          sel_cur;

  irq_pri_sel #(.VW(VW)) u_pri (
    .exc_req (exc_req),
    .exc_vec (exc_vec),
    .trap_en (flags[TF_BIT]),
    .nmi_req (nmi_req),
    .ovr_req (ovr_req),
    .ext_req (intr_req),
    .ext_en  (flags[IF_BIT]),
    .swi_req (swi_req),
    .swi_vec (swi_vec),
    .src     (sel_src),
    .vec     (sel_vec),
    .use_cur (sel_cur)
  );

  irq_addr_gen #(.AW(AW), .DW(DW), .VW(VW)) u_addr (
    .state (state),
    .ss    (ss_i),
    .sp    (sp),
    .vec   (vec_q),
    .addr  (mem_addr)
  );

  // next-state logic
  always_comb begin
    state_n   = state;
    flags_n   = flags;
    cs_n      = cs;
    ip_n      = ip;
    sp_n      = sp;
    ret_n     = ret_q;
    off_n     = off_q;
    vec_n     = vec_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      ST_IDLE: begin
        if (instr_done) begin
          if (sel_src == SRC_NONE) begin
            ip_n = next_ip;
          end else begin
            vec_n   = sel_vec;
            ret_n   = sel_cur ? ip : next_ip;
            state_n = (sel_src == SRC_EXT) ? ST_ACK : ST_PSH_F;
          end
        end else if (iret_req) begin
          state_n = ST_POP_IP;
        end else if (wr_en) begin
          flags_n = wr_flags;
          cs_n    = wr_cs;
          ip_n    = wr_ip;
          sp_n    = wr_sp;
        end
      end
      ST_ACK: begin
        vec_n   = intr_vec;
        state_n = ST_PSH_F;
      end
      ST_PSH_F: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = flags;
        sp_n      = sp - DW'(2);
        flags_n[IF_BIT] = 1'b0;
        flags_n[TF_BIT] = 1'b0;
        state_n   = ST_PSH_CS;
      end
      ST_PSH_CS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = cs;
        sp_n      = sp - DW'(2);
        state_n   = ST_PSH_IP;
      end
      ST_PSH_IP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ret_q;
        sp_n      = sp - DW'(2);
        state_n   = ST_RD_OFF;
      end
      ST_RD_OFF: begin
        mem_req = 1'b1;
        state_n = ST_RD_SEG;
      end
      ST_RD_SEG: begin
        mem_req = 1'b1;
        off_n   = mem_rdata;
        state_n = ST_LOAD;
      end
      ST_LOAD: begin
        ip_n    = off_q;
        cs_n    = mem_rdata;
        state_n = ST_IDLE;
      end
      ST_POP_IP: begin
        mem_req = 1'b1;
        state_n = ST_POP_CS;
      end
      ST_POP_CS: begin
        mem_req = 1'b1;
        ip_n    = mem_rdata;
        state_n = ST_POP_F;
      end
      ST_POP_F: begin
        mem_req = 1'b1;
        cs_n    = mem_rdata;
        state_n = ST_POP_END;
      end
      ST_POP_END: begin
        flags_n = mem_rdata;
        sp_n    = sp + DW'(6);
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      flags <= FLAGS_RST;
      cs    <= '0;
      ip    <= '0;
      sp    <= '0;
      ret_q <= '0;
      off_q <= '0;
      vec_q <= '0;
    end else begin
      state <= state_n;
      flags <= flags_n;
      cs    <= cs_n;
      ip    <= ip_n;
      sp    <= sp_n;
      ret_q <= ret_n;
      off_q <= off_n;
      vec_q <= vec_n;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign inta    = (state == ST_ACK);
  assign flags_o = flags;
  assign cs_o    = cs;
  assign ip_o    = ip;
  assign sp_o    = sp;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          inta,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] flags_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] ss_i
);

  // R9
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R8
  inta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> !inta);

  // R5
  flags_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (flags_o[9] == 1'b0 && flags_o[8] == 1'b0));

  // R4
  push_sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp_o == $past(sp_o) - 16'd2));

  // R4
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ({ss_i, 4'h0} + {4'h0, sp_o - 16'd2})));

endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .inta     (inta),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .flags_o  (flags_o),
  .sp_o     (sp_o),
  .ss_i     (ss_i)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0;
  logic [15:0] next_ip = '0;
  logic        iret_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_flags = '0, wr_cs = '0, wr_ip = '0, wr_sp = '0;
  logic [15:0] ss_i = 16'h2000;
  logic        exc_req = 1'b0, nmi_req = 1'b0, ovr_req = 1'b0;
  logic        intr_req = 1'b0, swi_req = 1'b0;
  logic [7:0]  exc_vec = '0, intr_vec = '0, swi_vec = '0;
  logic        inta, busy, mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [15:0] flags_o, cs_o, ip_o, sp_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int cyc = 0;

  logic [15:0] mem [logic [19:0]];

  always #10 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .next_ip(next_ip),
    .iret_req(iret_req), .wr_en(wr_en), .wr_flags(wr_flags), .wr_cs(wr_cs),
    .wr_ip(wr_ip), .wr_sp(wr_sp), .ss_i(ss_i), .exc_req(exc_req),
    .exc_vec(exc_vec), .nmi_req(nmi_req), .ovr_req(ovr_req),
    .intr_req(intr_req), .intr_vec(intr_vec), .swi_req(swi_req),
    .swi_vec(swi_vec), .inta(inta), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o),
    .sp_o(sp_o)
  );

  function automatic logic [15:0] rd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  // word memory: writes at the edge, read data one cycle later
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= rd(mem_addr);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual cycles %0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_arch(input logic [15:0] f, input logic [15:0] c,
                          input logic [15:0] i, input logic [15:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_flags = f; wr_cs = c; wr_ip = i; wr_sp = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_reqs();
    instr_done = 1'b0; exc_req = 1'b0; nmi_req = 1'b0; ovr_req = 1'b0;
    intr_req = 1'b0; swi_req = 1'b0;
  endtask

  // one boundary with the given sources, then checks the whole entry
  task automatic do_entry(input string tag, input bit e, input logic [7:0] ev,
                          input bit n, input bit o, input bit x, input bit s,
                          input logic [7:0] sv, input logic [7:0] exp_vec,
                          input bit exp_cur, input int exp_busy);
    logic [15:0] f0, c0, i0, s0, ret;
    logic [19:0] base;
    int bcnt, acnt;
    f0 = flags_o; c0 = cs_o; i0 = ip_o; s0 = sp_o;
    base = {ss_i, 4'h0};
    @(negedge clk);
    instr_done = 1'b1; next_ip = i0 + 16'd3;
    exc_req = e; exc_vec = ev; nmi_req = n; ovr_req = o; intr_req = x;
    swi_req = s; swi_vec = sv;
    @(negedge clk);
    clear_reqs();
    bcnt = 0; acnt = 0;
    while (busy) begin
      bcnt++;
      if (inta) acnt++;
      @(negedge clk);
    end
    ret = exp_cur ? i0 : i0 + 16'd3;
    chk({tag, " R9 busy cycles"}, bcnt, exp_busy);
    chk({tag, " R8 inta cycles"}, acnt, (exp_busy == 7) ? 1 : 0);
    chk({tag, " R4 stacked flags"}, rd(base + 20'(s0 - 16'd2)), f0);
    chk({tag, " R4 stacked cs"}, rd(base + 20'(s0 - 16'd4)), c0);
    chk({tag, " R7 stacked return"}, rd(base + 20'(s0 - 16'd6)), ret);
    chk({tag, " R4 sp"}, sp_o, s0 - 16'd6);
    chk({tag, " R6 R3 new ip"}, ip_o, 16'h1000 + 16'(exp_vec));
    chk({tag, " R6 R3 new cs"}, cs_o, 16'h8000 + 16'(exp_vec));
    chk({tag, " R5 flags"}, flags_o, f0 & 16'hFCFF);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 inta", inta, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 flags", flags_o, 16'h0002);
    chk("R1 cs", cs_o, 0);
    chk("R1 ip", ip_o, 0);
    chk("R1 sp", sp_o, 0);
  endtask

  task automatic t_plain();
    int w0;
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    chk("R11 load flags", flags_o, 16'h0202);
    chk("R11 load sp", sp_o, 16'h0200);
    w0 = wr_cnt;
    @(negedge clk);
    instr_done = 1'b1; next_ip = 16'h0104;
    @(negedge clk);
    instr_done = 1'b0;
    chk("R2 ip advanced", ip_o, 16'h0104);
    chk("R2 busy low", busy, 0);
    @(negedge clk);
    chk("R2 no writes", wr_cnt - w0, 0);
    chk("R2 cs kept", cs_o, 16'h1234);
  endtask

  task automatic t_nmi_and_return();
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    do_entry("nmi", 0, 0, 1, 0, 0, 0, 0, 8'd2, 0, 6);
    @(negedge clk);
    iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    begin
      int bc = 0;
      while (busy) begin bc++; @(negedge clk); end
      chk("R10 busy cycles", bc, 4);
    end
    chk("R10 ip", ip_o, 16'h0103);
    chk("R10 cs", cs_o, 16'h1234);
    chk("R10 flags", flags_o, 16'h0202);
    chk("R10 sp", sp_o, 16'h0200);
  endtask

  task automatic t_fault_addr();
    set_arch(16'h0002, 16'h1234, 16'h0100, 16'h0200);
    do_entry("retry13", 1, 8'd13, 0, 0, 0, 0, 0, 8'd13, 1, 6);
    set_arch(16'h0002, 16'h1234, 16'h0100, 16'h0200);
    do_entry("next4", 1, 8'd4, 0, 0, 0, 0, 0, 8'd4, 0, 6);
    set_arch(16'h0002, 16'h1234, 16'h0100, 16'h0200);
    do_entry("swi13", 0, 0, 0, 0, 0, 1, 8'd13, 8'd13, 0, 6);
  endtask

  task automatic t_priority();
    intr_vec = 8'h48;
    set_arch(16'h0302, 16'h1234, 16'h0100, 16'h0200);
    do_entry("exc_over_all", 1, 8'd4, 1, 1, 1, 1, 8'h21, 8'd4, 0, 6);
    set_arch(16'h0302, 16'h1234, 16'h0100, 16'h0200);
    do_entry("step_over_nmi", 0, 0, 1, 1, 1, 1, 8'h21, 8'd1, 0, 6);
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    do_entry("nmi_over_ovr", 0, 0, 1, 1, 1, 1, 8'h21, 8'd2, 0, 6);
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    do_entry("ovr_over_ext", 0, 0, 0, 1, 1, 1, 8'h21, 8'd9, 0, 6);
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    do_entry("ext_over_swi", 0, 0, 0, 0, 1, 1, 8'h21, 8'h48, 0, 7);
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    do_entry("swi_alone", 0, 0, 0, 0, 0, 1, 8'h21, 8'h21, 0, 6);
  endtask

  task automatic t_intr_gate();
    set_arch(16'h0002, 16'h1234, 16'h0100, 16'h0200);
    @(negedge clk);
    instr_done = 1'b1; next_ip = 16'h0103; intr_req = 1'b1;
    @(negedge clk);
    clear_reqs();
    chk("R8 masked busy", busy, 0);
    chk("R8 masked inta", inta, 0);
    chk("R8 masked ip", ip_o, 16'h0103);
    chk("R8 masked sp", sp_o, 16'h0200);
  endtask

  task automatic t_busy_ignore();
    int w0;
    set_arch(16'h0202, 16'h1234, 16'h0100, 16'h0200);
    w0 = wr_cnt;
    @(negedge clk);
    instr_done = 1'b1; next_ip = 16'h0103; nmi_req = 1'b1;
    @(negedge clk);
    clear_reqs();
    @(negedge clk);
    instr_done = 1'b1; nmi_req = 1'b1; wr_en = 1'b1; wr_sp = 16'h0F00;
    @(negedge clk);
    clear_reqs(); wr_en = 1'b0;
    while (busy) @(negedge clk);
    chk("R9 writes during one entry", wr_cnt - w0, 3);
    chk("R9 sp after ignored inputs", sp_o, 16'h01FA);
    chk("R9 ip after ignored inputs", ip_o, 16'h1002);
    @(negedge clk);
    chk("R9 stays idle", busy, 0);
  endtask

  task automatic t_wr_vs_boundary();
    set_arch(16'h0002, 16'h1234, 16'h0100, 16'h0200);
    @(negedge clk);
    instr_done = 1'b1; next_ip = 16'h0107;
    wr_en = 1'b1; wr_cs = 16'h5555; wr_ip = 16'h6666; wr_sp = 16'h7777;
    @(negedge clk);
    instr_done = 1'b0; wr_en = 1'b0;
    chk("R11 ignored cs", cs_o, 16'h1234);
    chk("R11 ignored sp", sp_o, 16'h0200);
    chk("R11 ip from boundary", ip_o, 16'h0107);
  endtask

  initial begin
    for (int v = 0; v < 256; v++) begin
      mem[20'(v * 4)]     = 16'h1000 + 16'(v);
      mem[20'(v * 4 + 2)] = 16'h8000 + 16'(v);
    end
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_plain();
    t_nmi_and_return();
    t_fault_addr();
    t_priority();
    t_intr_gate();
    t_busy_ignore();
    t_wr_vs_boundary();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule